// File: doc/BRIEF.md
# Two-Stage SPI Bit-Rate Generator

This block makes the serial clock timing for an SPI master from the system clock. Two counters are chained. The first divides the system clock by an even prescale value between 2 and 254. The second divides the result by one plus an 8-bit rate value between 0 and 255. The serial clock therefore runs at the system clock divided by prescale × (1 + rate). This gives a fastest setting of one half of the system clock and a slowest setting of one part in 254 × 256.

The block emits a one-cycle `half_tick` pulse at every half-period of that serial clock. It also drives a serial clock, `sclk`, that changes level on each tick, so the duty cycle is 50%. Software chooses the divisors and loads them together with a single write strobe. The block holds the loaded values until the next strobe. It reports through `prescale_bad` whether the loaded prescale was outside the legal set. All pins are plain control and status pins. There is no data stream and therefore no valid/ready handshake.

Top module: `spi_bitrate_gen`

## Requirements
- R1: After reset, `half_tick`, `sclk` and `prescale_bad` are 0. The loaded divisors are prescale 2 and rate 0, so enabling without a write gives a tick on every cycle.
- R2: With prescale P and rate R loaded and `en` high, consecutive `half_tick` pulses are exactly (P/2)·(R+1) system cycles apart, so one serial clock period is P·(R+1) cycles.
- R3: `sclk` is low while idle. It changes level in exactly the cycles in which `half_tick` is high, so it is high after the first tick of a run and low after the second.
- R4: Bit 0 of `cfg_prescale` is ignored: an odd value v divides exactly as v−1 does (for example 255 divides as 254).
- R5: A prescale value of 0 or 1 divides as 2.
- R6: `prescale_bad` becomes 1 in the cycle after a write whose prescale value is odd or below 2. It becomes 0 in the cycle after a write of an even value from 2 to 254.
- R7: The rate field covers 0 to 255. With prescale 254 and rate 255 the first half-period lasts 127·256 = 32512 cycles.
- R8: A write (`cfg_wr` high for one cycle) restarts both counters and returns `sclk` low. `half_tick` is 0 in the cycle after the write, and the first tick comes N = (P/2)·(R+1) cycles after that cycle. No tick comes earlier, even if the write happens in the middle of a period.
- R9: While `en` is low, the counters are held cleared and `half_tick` and `sclk` stay 0. When `en` rises, the first tick comes N cycles after the first cycle with `en` high.
- R10: Changes on `cfg_prescale` and `cfg_rate` without `cfg_wr` have no effect on tick spacing or on `prescale_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counters cleared |
| cfg_wr | input | 1 | Load strobe for both divisor fields; also restarts the counters |
| cfg_prescale | input | 8 | First-stage divisor; even values 2..254 are legal |
| cfg_rate | input | 8 | Second-stage field; the divide factor is this value plus one |
| half_tick | output | 1 | One-cycle pulse at each serial half-period |
| sclk | output | 1 | Serial clock, 50% duty, low when idle |
| prescale_bad | output | 1 | The last loaded prescale was odd or below 2 |

## Verification
A first-stage count that is off by one shows up as tick spacing that is wrong by R+1 cycles. This is visible at the second tick, after at most two half-periods. A stuck second-stage count shows up as a missing tick or as a gap R+1 times too short. A wrong restart on a write or on `en` shows up as an early first tick, so the bench measures the first tick from the write or enable cycle and also the gap between ticks. A wrong level on `sclk` shows up at the very next tick.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int BRG_PRESC_W = 8;
  localparam int BRG_RATE_W  = 8;

  // Half of the first-stage divisor after dropping bit 0 and clamping to 1.
  function automatic logic [BRG_PRESC_W-2:0] half_of_presc(
    input logic [BRG_PRESC_W-1:0] p
  );
    logic [BRG_PRESC_W-2:0] h;
    h = p[BRG_PRESC_W-1:1];
    if (h == '0) h = {{(BRG_PRESC_W-2){1'b0}}, 1'b1};
    return h;
  endfunction

  // The prescale is outside the legal set when it is odd or below 2.
  function automatic logic presc_is_bad(input logic [BRG_PRESC_W-1:0] p);
    return p[0] | (p[BRG_PRESC_W-1:1] == '0);
  endfunction
endpackage

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg
  import spi_brg_pkg::*;
#(
  parameter int PW = BRG_PRESC_W,
  parameter int RW = BRG_RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PW-1:0] presc_in,
  input  logic [RW-1:0] rate_in,
  output logic [PW-2:0] half_q,
  output logic [RW-1:0] rate_q,
  output logic          bad_q
);
  localparam logic [PW-2:0] HALF_MIN = {{(PW-2){1'b0}}, 1'b1};

  logic [PW-2:0] half_d;
  logic          bad_d;

  always_comb begin
    half_d = presc_in[PW-1:1];
    if (half_d == '0) half_d = HALF_MIN;
    bad_d = presc_in[0] | (presc_in[PW-1:1] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= HALF_MIN;
      rate_q <= '0;
      bad_q  <= 1'b0;
    end else if (wr) begin
      half_q <= half_d;
      rate_q <= rate_in;
      bad_q  <= bad_d;
    end
  end

  // R5
  half_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);

  // R6
  bad_flag_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> bad_q == ($past(presc_in[0]) || ($past(presc_in) < 2)));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(half_q) && $stable(rate_q) && $stable(bad_q));
endmodule

// File: rtl/brg_div_stage.sv
module brg_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R9
  cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/brg_sclk_out.sv
module brg_sclk_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_in,
  output logic half_tick,
  output logic sclk
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      half_tick <= 1'b0;
      sclk      <= 1'b0;
    end else begin
      half_tick <= tick_in;
      sclk      <= sclk ^ tick_in;
    end
  end

  // R3
  sclk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) && !clr |=> (sclk != $past(sclk)) == half_tick);
endmodule

// File: rtl/spi_bitrate_gen.sv
module spi_bitrate_gen
  import spi_brg_pkg::*;
#(
  parameter int PW = BRG_PRESC_W,
  parameter int RW = BRG_RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_prescale,
  input  logic [RW-1:0] cfg_rate,
  output logic          half_tick,
  output logic          sclk,
  output logic          prescale_bad
);
  localparam int HW = PW - 1;

  logic [HW-1:0] half_q;
  logic [RW-1:0] rate_q;
  logic          hold;
  logic          pre_wrap;
  logic          post_wrap;

  // Counters run only when enabled and not being reloaded.
  assign hold = !en || cfg_wr;

  brg_cfg_reg #(.PW(PW), .RW(RW)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .presc_in (cfg_prescale),
    .rate_in  (cfg_rate),
    .half_q   (half_q),
    .rate_q   (rate_q),
    .bad_q    (prescale_bad)
  );

  brg_div_stage #(.W(HW)) pre_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold),
    .step  (1'b1),
    .limit (half_q - HW'(1)),
    .wrap  (pre_wrap)
  );

  brg_div_stage #(.W(RW)) post_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold),
    .step  (pre_wrap),
    .limit (rate_q),
    .wrap  (post_wrap)
  );

  brg_sclk_out out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hold),
    .tick_in   (post_wrap),
    .half_tick (half_tick),
    .sclk      (sclk)
  );

  // R9
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !half_tick && !sclk);

  // R8
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !half_tick && !sclk);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> !half_tick && !sclk && !prescale_bad);
endmodule

// File: tb/spi_bitrate_gen_tb_top.sv
`timescale 1ns/1ps
module spi_bitrate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_prescale = 8'd0;
  logic [7:0] cfg_rate = 8'd0;
  logic       half_tick;
  logic       sclk;
  logic       prescale_bad;

  int checks = 0;
  int failures = 0;
  localparam int LIMIT = 40000;

  always #5 clk = ~clk;

  spi_bitrate_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cfg_wr       (cfg_wr),
    .cfg_prescale (cfg_prescale),
    .cfg_rate     (cfg_rate),
    .half_tick    (half_tick),
    .sclk         (sclk),
    .prescale_bad (prescale_bad)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int n_of(input int p, input int r);
    int h;
    h = p / 2;
    if (h == 0) h = 1;
    return h * (r + 1);
  endfunction

  // Counts negedges from the current one until half_tick is seen.
  task automatic to_tick(output int n);
    n = 0;
    while (!half_tick && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Gap from the current tick to the next.
  task automatic gap(output int n);
    @(negedge clk);
    n = 1;
    while (!half_tick && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Write strobe; returns at the negedge of the cycle after the write.
  task automatic do_write(input int p, input int r);
    @(negedge clk);
    cfg_prescale = 8'(p);
    cfg_rate     = 8'(r);
    cfg_wr       = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    chk("R1 tick after reset", int'(half_tick), 0);
    chk("R1 sclk after reset", int'(sclk), 0);
    chk("R1 bad after reset", int'(prescale_bad), 0);
    en = 1'b1;
    to_tick(n);
    chk("R1 default first tick", n, 1);
    gap(n);
    chk("R1 default gap", n, 1);
  endtask

  task automatic t_rate(input int p, input int r, input string tag);
    int n;
    int e;
    e = n_of(p, r);
    do_write(p, r);
    chk({tag, " no tick after write R8"}, int'(half_tick), 0);
    to_tick(n);
    chk({tag, " first tick"}, n, e);
    chk({tag, " sclk high after first R3"}, int'(sclk), 1);
    gap(n);
    chk({tag, " gap"}, n, e);
    chk({tag, " sclk low after second R3"}, int'(sclk), 0);
  endtask

  task automatic t_flag(input int p, input int exp_bad, input string tag);
    do_write(p, 0);
    chk(tag, int'(prescale_bad), exp_bad);
  endtask

  task automatic t_slowest();
    int n;
    do_write(254, 255);
    to_tick(n);
    chk("R7 slowest first tick", n, 32512);
  endtask

  task automatic t_midwrite();
    int n;
    do_write(4, 2);
    to_tick(n);
    repeat (4) @(negedge clk);
    do_write(4, 2);
    chk("R8 sclk low after mid write", int'(sclk), 0);
    to_tick(n);
    chk("R8 first tick after mid write", n, 6);
  endtask

  task automatic t_enable();
    int n;
    do_write(6, 1);
    @(negedge clk);
    en = 1'b0;
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (half_tick || sclk) n++;
    end
    chk("R9 quiet while disabled", n, 0);
    en = 1'b1;
    to_tick(n);
    chk("R9 first tick after enable", n, 6);
  endtask

  task automatic t_nowrite();
    int n;
    do_write(6, 0);
    cfg_prescale = 8'd40;
    cfg_rate     = 8'd9;
    to_tick(n);
    gap(n);
    chk("R10 gap unchanged without write", n, 3);
    chk("R10 flag unchanged", int'(prescale_bad), 0);
    cfg_prescale = 8'd1;
    repeat (3) @(negedge clk);
    chk("R10 flag unchanged by odd input", int'(prescale_bad), 0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate(4, 2, "R2 p4 r2");
    t_rate(6, 0, "R2 p6 r0");
    t_rate(2, 0, "R2 fastest");
    t_rate(20, 3, "R2 p20 r3");
    t_rate(255, 0, "R4 odd 255");
    t_rate(7, 1, "R4 odd 7");
    t_rate(0, 1, "R5 zero");
    t_rate(1, 2, "R5 one");
    t_flag(3, 1, "R6 odd flagged");
    t_flag(8, 0, "R6 even cleared");
    t_flag(0, 1, "R6 zero flagged");
    t_flag(254, 0, "R6 max legal");
    t_slowest();
    t_midwrite();
    t_enable();
    t_nowrite();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule